// File: doc/BRIEF.md
# Torus Minimal Adaptive Router

This block picks the next hop for a packet at one node of a three-dimensional wraparound torus. Each cycle it can accept a packet header holding the destination coordinates, a deposit flag and a chunk count. It compares the header with the node's own coordinates and with the configured ring size of each dimension. For every dimension it works out whether the packet still has to move and which way round the ring is shorter. It then grants one of the productive output ports that is ready, or signals local delivery when the packet has arrived.

Any productive dimension may carry the packet, so the choice adapts to which neighbour ports are ready. A rotating priority across the X, Y and Z dimensions keeps any one dimension from being favoured. If every productive port is busy, the header is held inside the block and a stall flag is raised until a port frees. A packet with the deposit flag set is also handed to the local node when it is one dimension away from its destination, and it is still forwarded. All results are registered and appear one cycle after the header is accepted.

Top module: `torus_route_sel`

## Requirements
- R1: The header is `{dst_z, dst_y, dst_x, deposit, chunks}`: bits [2:0] are the chunk count c, bit 3 is the deposit flag, and bits [6:4], [9:7] and [12:10] are destination X, Y and Z. With each routing result, `len_bytes_o` reports (c+1)*32, which covers 32 to 256 bytes.
- R2: When the destination equals the node coordinates, `local_o` is 1 and `port_sel_o` is zero.
- R3: In each dimension the offset is d = (dst - node) mod size. For 0 < d <= size/2 the plus port is used, otherwise the minus port, so an exact tie at half the ring goes plus. Port bits are 0 X+, 1 X-, 2 Y+, 3 Y-, 4 Z+, 5 Z-.
- R4: Only a port that is productive and whose `port_ready_i` bit was 1 at the accepting edge is selected. At most one port bit is set.
- R5: When no productive port is ready, `stall_o` is 1 and `route_valid_o` is 0. The header is held, new headers are ignored while stalled, and the held packet is routed after the first edge at which one of its productive ports is ready.
- R6: A rotating pointer over X, Y, Z starts at X after reset. The grant goes to the first ready productive dimension at or after the pointer, and the pointer then moves to the dimension after the one granted.
- R7: With the deposit flag set and the node differing from the destination in exactly one dimension, `local_o` is 1 together with a forwarding port. When the node differs in two or more dimensions, `local_o` stays 0.
- R8: Results are registered: they appear after the clock edge that samples `hdr_valid_i` and hold for one cycle only.
- R9: While reset is low, every output is 0.
- R10: A ring size of 2 routes correctly: an offset of 1 goes to the plus port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_valid_i | input | 1 | Header present this cycle |
| hdr_i | input | 3*COORD_W+4 | Packet header |
| node_x_i | input | COORD_W | Own X coordinate |
| node_y_i | input | COORD_W | Own Y coordinate |
| node_z_i | input | COORD_W | Own Z coordinate |
| size_x_i | input | COORD_W+1 | Ring size in X |
| size_y_i | input | COORD_W+1 | Ring size in Y |
| size_z_i | input | COORD_W+1 | Ring size in Z |
| port_ready_i | input | 6 | Neighbour port ready flags |
| route_valid_o | output | 1 | Routing result valid |
| local_o | output | 1 | Deliver to this node |
| port_sel_o | output | 6 | One-hot forwarding port |
| len_bytes_o | output | 9 | Packet length in bytes |
| stall_o | output | 1 | Packet held, no productive port ready |

## Verification
The bench targets the wraparound offsets. It uses a destination numerically below the node, an offset of exactly half the ring and a ring of size two. A design that dropped the modulo or broke the tie the wrong way would send these packets round the longer side. It holds a stalled packet while offering a different, local header. A design that did not latch the held header would report local delivery instead of the stalled forward. It also steps the rotating pointer through all three dimensions and then past a busy dimension, and it checks the deposit flag at nodes one and two dimensions away. Either error would show as the wrong port or a wrong local flag.

// File: rtl/torus_route_pkg.sv
package torus_route_pkg;
  localparam int LEN_W      = 3;
  localparam int NUM_DIM    = 3;
  localparam int NUM_PORT   = 2 * NUM_DIM;
  localparam int BYTES_W    = 9;
  localparam int CHUNK_LOG2 = 5;

  function automatic logic [BYTES_W-1:0] chunks_to_bytes(input logic [LEN_W-1:0] c);
    return ({{(BYTES_W-LEN_W){1'b0}}, c} + BYTES_W'(1)) << CHUNK_LOG2;
  endfunction
endpackage

// File: rtl/torus_dim_route.sv
module torus_dim_route #(
  parameter int COORD_W = 3
) (
  input  logic [COORD_W-1:0] node_i,
  input  logic [COORD_W-1:0] dst_i,
  input  logic [COORD_W:0]   size_i,
  output logic               need_o,
  output logic               plus_o
);
  logic [COORD_W:0]   ofs;
  logic [COORD_W+1:0] ofs_x2;

  always_comb begin
    if (dst_i >= node_i) ofs = {1'b0, dst_i} - {1'b0, node_i};
    else                 ofs = {1'b0, dst_i} + size_i - {1'b0, node_i};
    ofs_x2 = {ofs, 1'b0};
    need_o = (ofs != '0);
    // tie at half ring goes plus
    plus_o = (ofs_x2 <= {1'b0, size_i});
  end
endmodule

// File: rtl/torus_rr_arb.sv
module torus_rr_arb #(
  parameter int N = 3,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic         adv_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  logic [PW-1:0] ptr_q, nxt_ptr;

  always_comb begin
    gnt_o   = '0;
    any_o   = 1'b0;
    nxt_ptr = ptr_q;
    for (int i = 0; i < N; i++) begin
      int idx;
      idx = (int'(ptr_q) + i) % N;
      if (!any_o && req_i[idx]) begin
        any_o      = 1'b1;
        gnt_o[idx] = 1'b1;
        nxt_ptr    = PW'((idx + 1) % N);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= nxt_ptr;
  end

  // R6
  gnt_in_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_i) == '0);
  // R6
  gnt_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  // R6
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(ptr_q) < N);
endmodule

// File: rtl/torus_route_sel.sv
module torus_route_sel
  import torus_route_pkg::*;
#(
  parameter int COORD_W = 3,
  localparam int HDR_W = 3 * COORD_W + LEN_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hdr_valid_i,
  input  logic [HDR_W-1:0]   hdr_i,
  input  logic [COORD_W-1:0] node_x_i,
  input  logic [COORD_W-1:0] node_y_i,
  input  logic [COORD_W-1:0] node_z_i,
  input  logic [COORD_W:0]   size_x_i,
  input  logic [COORD_W:0]   size_y_i,
  input  logic [COORD_W:0]   size_z_i,
  input  logic [NUM_PORT-1:0] port_ready_i,
  output logic               route_valid_o,
  output logic               local_o,
  output logic [NUM_PORT-1:0] port_sel_o,
  output logic [BYTES_W-1:0] len_bytes_o,
  output logic               stall_o
);
  localparam int DEP_BIT = LEN_W;
  localparam int DST_LSB = LEN_W + 1;

  logic [HDR_W-1:0]   held_q, act_hdr;
  logic               act_valid;
  logic [COORD_W-1:0] node_c [NUM_DIM];
  logic [COORD_W-1:0] dst_c  [NUM_DIM];
  logic [COORD_W:0]   size_c [NUM_DIM];
  logic [NUM_DIM-1:0] need, plus, req, gnt;
  logic [NUM_PORT-1:0] port_n;
  logic               any_gnt, at_dst, one_away, fwd, stall_n, done_n;

  assign act_valid = stall_o | hdr_valid_i;
  assign act_hdr   = stall_o ? held_q : hdr_i;

  assign node_c[0] = node_x_i;
  assign node_c[1] = node_y_i;
  assign node_c[2] = node_z_i;
  assign size_c[0] = size_x_i;
  assign size_c[1] = size_y_i;
  assign size_c[2] = size_z_i;

  for (genvar d = 0; d < NUM_DIM; d++) begin : g_dim
    assign dst_c[d] = act_hdr[DST_LSB + d*COORD_W +: COORD_W];

    torus_dim_route #(.COORD_W(COORD_W)) u_dim (
      .node_i (node_c[d]),
      .dst_i  (dst_c[d]),
      .size_i (size_c[d]),
      .need_o (need[d]),
      .plus_o (plus[d])
    );

    assign req[d]        = need[d] & (plus[d] ? port_ready_i[2*d] : port_ready_i[2*d+1]);
    assign port_n[2*d]   = gnt[d] & plus[d];
    assign port_n[2*d+1] = gnt[d] & ~plus[d];
  end

  assign at_dst   = (need == '0);
  assign one_away = (need != '0) && ((need & (need - 1'b1)) == '0);
  assign fwd      = act_valid & ~at_dst & any_gnt;
  assign stall_n  = act_valid & ~at_dst & ~any_gnt;
  assign done_n   = act_valid & (at_dst | any_gnt);

  torus_rr_arb #(.N(NUM_DIM)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .adv_i  (fwd),
    .gnt_o  (gnt),
    .any_o  (any_gnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      route_valid_o <= 1'b0;
      local_o       <= 1'b0;
      port_sel_o    <= '0;
      len_bytes_o   <= '0;
      stall_o       <= 1'b0;
      held_q        <= '0;
    end else begin
      route_valid_o <= done_n;
      local_o       <= act_valid & (at_dst | (act_hdr[DEP_BIT] & one_away & any_gnt));
      port_sel_o    <= fwd ? port_n : '0;
      len_bytes_o   <= done_n ? chunks_to_bytes(act_hdr[LEN_W-1:0]) : '0;
      stall_o       <= stall_n;
      if (stall_n) held_q <= act_hdr;
    end
  end

  // R4
  port_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(port_sel_o));
  // R4
  port_was_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_valid_o && port_sel_o != '0) |-> ((port_sel_o & $past(port_ready_i)) != '0));
  // R5
  stall_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !route_valid_o);
  // R2
  local_no_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (route_valid_o && port_sel_o == '0) |-> local_o);
  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !route_valid_o |-> (port_sel_o == '0 && !local_o && len_bytes_o == '0));
endmodule

// File: tb/tb_torus_route_sel.sv
`timescale 1ns/1ps
module tb_torus_route_sel;
  localparam int CW = 3;
  localparam int HW = 3*CW + 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hv = 1'b0;
  logic [HW-1:0] hdr = '0;
  logic [CW-1:0] nx = '0, ny = '0, nz = '0;
  logic [CW:0]   sx = 4'd8, sy = 4'd8, sz = 4'd8;
  logic [5:0]    rdy = '0;
  logic          rv, loc, stl;
  logic [5:0]    psel;
  logic [8:0]    lb;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  torus_route_sel #(.COORD_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .hdr_valid_i(hv), .hdr_i(hdr),
    .node_x_i(nx), .node_y_i(ny), .node_z_i(nz),
    .size_x_i(sx), .size_y_i(sy), .size_z_i(sz),
    .port_ready_i(rdy), .route_valid_o(rv), .local_o(loc),
    .port_sel_o(psel), .len_bytes_o(lb), .stall_o(stl)
  );

  typedef struct packed {
    logic [3:0] s;
    logic [2:0] mx, my, mz, dx, dy, dz;
    logic       dep;
    logic [2:0] len;
    logic [5:0] rdy;
    logic       e_loc;
    logic [5:0] e_port;
  } vec_t;

  // port bits: 0 X+,1 X-,2 Y+,3 Y-,4 Z+,5 Z-
  localparam int NV = 11;
  localparam vec_t VT [NV] = '{
    '{4'd8, 3'd3,3'd3,3'd3, 3'd3,3'd3,3'd3, 1'b0, 3'd7, 6'h3F, 1'b1, 6'h00}, // R2 R1
    '{4'd8, 3'd0,3'd0,3'd0, 3'd3,3'd0,3'd0, 1'b0, 3'd0, 6'h3F, 1'b0, 6'h01}, // R3
    '{4'd8, 3'd0,3'd0,3'd0, 3'd5,3'd0,3'd0, 1'b0, 3'd1, 6'h3F, 1'b0, 6'h02}, // R3
    '{4'd8, 3'd0,3'd0,3'd0, 3'd4,3'd0,3'd0, 1'b0, 3'd2, 6'h3F, 1'b0, 6'h01}, // R3 tie
    '{4'd8, 3'd6,3'd0,3'd0, 3'd1,3'd0,3'd0, 1'b0, 3'd3, 6'h3F, 1'b0, 6'h01}, // R3 wrap
    '{4'd8, 3'd1,3'd0,3'd0, 3'd6,3'd0,3'd0, 1'b0, 3'd4, 6'h3F, 1'b0, 6'h02}, // R3 wrap
    '{4'd8, 3'd0,3'd0,3'd0, 3'd2,3'd5,3'd0, 1'b0, 3'd5, 6'h0C, 1'b0, 6'h08}, // R4
    '{4'd8, 3'd0,3'd0,3'd0, 3'd0,3'd0,3'd1, 1'b1, 3'd6, 6'h3F, 1'b1, 6'h10}, // R7
    '{4'd8, 3'd0,3'd0,3'd0, 3'd0,3'd2,3'd1, 1'b1, 3'd6, 6'h10, 1'b0, 6'h10}, // R7
    '{4'd8, 3'd0,3'd0,3'd0, 3'd7,3'd7,3'd7, 1'b0, 3'd0, 6'h20, 1'b0, 6'h20}, // R3 R4
    '{4'd2, 3'd1,3'd0,3'd0, 3'd0,3'd0,3'd0, 1'b0, 3'd1, 6'h3F, 1'b0, 6'h01}  // R10
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_hdr(input logic [2:0] dx, dy, dz, input logic dep, input logic [2:0] len);
    hdr = {dz, dy, dx, dep, len};
  endtask

  task automatic do_reset();
    @(negedge clk);
    hv = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // drive for one edge, leave at the negedge after it
  task automatic send_one();
    hv = 1'b1;
    @(negedge clk);
    hv = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    #3;
    check("R9 valid", 16'(rv), 16'd0);
    check("R9 port", 16'(psel), 16'd0);
    check("R9 stall", 16'(stl), 16'd0);
    check("R9 local", 16'(loc), 16'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      sx = VT[i].s; sy = VT[i].s; sz = VT[i].s;
      nx = VT[i].mx; ny = VT[i].my; nz = VT[i].mz;
      rdy = VT[i].rdy;
      set_hdr(VT[i].dx, VT[i].dy, VT[i].dz, VT[i].dep, VT[i].len);
      send_one();
      check("R8 valid", 16'(rv), 16'd1);
      check("R2 R7 local", 16'(loc), 16'(VT[i].e_loc));
      check("R3 R4 R10 port", 16'(psel), 16'(VT[i].e_port));
      check("R1 bytes", 16'(lb), 16'((VT[i].len + 1) * 32));
    end

    // R8 latency: nothing before the edge, one cycle after
    sx = 4'd8; sy = 4'd8; sz = 4'd8;
    nx = 3'd0; ny = 3'd0; nz = 3'd0;
    rdy = 6'h3F;
    do_reset();
    @(negedge clk);
    set_hdr(3'd0, 3'd0, 3'd0, 1'b0, 3'd0);
    hv = 1'b1;
    #1;
    check("R8 early", 16'(rv), 16'd0);
    @(negedge clk);
    hv = 1'b0;
    check("R8 valid", 16'(rv), 16'd1);
    @(negedge clk);
    check("R8 one cycle", 16'(rv), 16'd0);

    // R5 stall and hold
    do_reset();
    set_hdr(3'd2, 3'd0, 3'd0, 1'b0, 3'd5);
    rdy = 6'h02;
    send_one();
    check("R5 stall", 16'(stl), 16'd1);
    check("R5 no valid", 16'(rv), 16'd0);
    set_hdr(3'd0, 3'd0, 3'd0, 1'b0, 3'd0);
    send_one();
    check("R5 still stall", 16'(stl), 16'd1);
    check("R5 new hdr ignored", 16'(rv), 16'd0);
    rdy = 6'h01;
    @(negedge clk);
    check("R5 release valid", 16'(rv), 16'd1);
    check("R5 held port", 16'(psel), 16'h01);
    check("R5 held local", 16'(loc), 16'd0);
    check("R5 held bytes", 16'(lb), 16'd192);
    check("R5 stall clear", 16'(stl), 16'd0);

    // R6 rotating priority
    do_reset();
    rdy = 6'h3F;
    set_hdr(3'd1, 3'd1, 3'd1, 1'b0, 3'd0);
    send_one();
    check("R6 first X", 16'(psel), 16'h01);
    send_one();
    check("R6 then Y", 16'(psel), 16'h04);
    send_one();
    check("R6 then Z", 16'(psel), 16'h10);
    send_one();
    check("R6 wraps X", 16'(psel), 16'h01);
    rdy = 6'h11;
    send_one();
    check("R6 skip busy Y", 16'(psel), 16'h10);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule